// File: doc/BRIEF.md
# SDMA Boundary Address Generator

This block produces the system-memory address for a single-address DMA engine inside an SD host controller. Software loads a start address, a block size in bytes, a block count and a buffer-boundary setting through a small register port, then pulses a start strobe. Each 32-bit data word then moves as one beat on a valid/ready handshake: the data path raises `beat_valid`, the block raises `beat_ready`, and a beat is taken on every clock edge where both are high. The generator steps the address by four bytes per taken beat, counts bytes into blocks and blocks into the transfer, and ends the transfer on its own.

The buffer in system memory is contiguous only up to a power-of-two size chosen by the boundary field, 4 KB times two to the field value (4 KB to 512 KB). While DMA is enabled, a beat that moves the address onto a multiple of that size stalls the stream: `beat_ready` drops, a sticky interrupt flag is set, and the stream stays stalled until software writes a new value to the address register. Back-pressure rule: the data path may hold `beat_valid` high for as long as it likes; no beat is taken while `beat_ready` is low, and `beat_ready` depends only on registered state, never on `beat_valid`.

Top module: `sdma_bndry_agen`

## Requirements
- R1: After reset, `mem_addr`, `beat_ready`, `busy`, `dma_irq` and `xfer_done` are 0 and every register reads 0.
- R2: While `dma_en` is 1, a taken beat whose new address is a multiple of 4096 << B (B is bits 14:12 of the register at offset 0x04) and is not the last beat of the transfer sets `dma_irq` and drops `beat_ready` at the same edge.
- R3: A stall holds `beat_ready` low until a write to the address register at offset 0x00; that write releases the stall at its edge. A stall raised in the same cycle as an address write wins.
- R4: While `dma_en` is 0, no boundary stall and no interrupt occur.
- R5: Each taken beat adds 4 to the address; `mem_addr` and a read of offset 0x00 give the current address, and an address write in the same cycle as a beat takes precedence.
- R6: A block ends once the bytes taken reach the block size (bits 9:0 of offset 0x04); after the number of blocks in offset 0x08 (bits 15:0) the transfer ends: `busy` and `beat_ready` fall and `xfer_done` is set at the edge that takes the last beat.
- R7: Offset 0x04 holds the boundary field at bits 14:12 and the block size at bits 9:0; other bits read 0. Writes to offsets 0x04 and 0x08 are ignored while `busy` is 1.
- R8: `dma_irq` (bit 0) and `xfer_done` (bit 1) of offset 0x0C are sticky and cleared by writing 1 to that bit; a flag set and a clear in the same cycle leave the flag set.
- R9: When the last beat of a transfer lands exactly on a boundary, `xfer_done` is set and no stall or interrupt occurs.
- R10: `xfer_start` is ignored while `busy` is 1 or while the block count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xfer_start | input | 1 | Start strobe for a transfer |
| dma_en | input | 1 | Enables boundary stalls and the interrupt |
| beat_valid | input | 1 | Data path offers one 32-bit word |
| beat_ready | output | 1 | Generator accepts a word this cycle |
| mem_addr | output | 32 | Current system-memory address |
| busy | output | 1 | Transfer in progress |
| dma_irq | output | 1 | Sticky boundary interrupt flag |
| xfer_done | output | 1 | Sticky transfer-complete flag |

## Verification
Two functions collide in one cycle here: the boundary test and the end-of-transfer test can both be true for one beat, and the sticky-flag set can meet a software clear. The bench provokes the first by placing a one-block transfer so its final word lands on a 4 KB multiple, and the second by timing a write-one-to-clear of the interrupt bit onto the exact edge where a stalling beat is taken with a continuously valid stream. A behavioural model, advanced every clock from the same inputs, predicts the outcome (completion rather than a stall; the flag left set) and is compared against every output on every cycle.

// File: rtl/sdma_agen_pkg.sv
package sdma_agen_pkg;
  localparam logic [7:0] OFS_ADDR = 8'h00;
  localparam logic [7:0] OFS_BSR  = 8'h04;
  localparam logic [7:0] OFS_BCNT = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam int         BND_LSB  = 12;
endpackage

// File: rtl/sdma_agen_regs.sv
module sdma_agen_regs
  import sdma_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 10,
  parameter int CNT_W  = 16,
  parameter int BND_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [BLK_W-1:0]  wr_size,
  input  logic [BND_W-1:0]  wr_bnd,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [1:0]        wr_clr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              set_irq,
  input  logic              set_done,
  output logic [BLK_W-1:0]  blk_size,
  output logic [BND_W-1:0]  bnd_sel,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic              irq_flag,
  output logic              done_flag,
  output logic [31:0]       reg_rdata
);
  logic cfg_wr_ok;
  logic clr_irq, clr_done;

  assign cfg_wr_ok = reg_we & ~busy;
  assign clr_irq   = reg_we & (reg_addr == OFS_STAT) & wr_clr[0];
  assign clr_done  = reg_we & (reg_addr == OFS_STAT) & wr_clr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_size  <= '0;
      bnd_sel   <= '0;
      blk_cnt   <= '0;
      irq_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (cfg_wr_ok && reg_addr == OFS_BSR) begin
        blk_size <= wr_size;
        bnd_sel  <= wr_bnd;
      end
      if (cfg_wr_ok && reg_addr == OFS_BCNT) blk_cnt <= wr_cnt;
      irq_flag  <= set_irq  | (irq_flag  & ~clr_irq);
      done_flag <= set_done | (done_flag & ~clr_done);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_ADDR: reg_rdata[ADDR_W-1:0] = cur_addr;
      OFS_BSR: begin
        reg_rdata[BND_LSB +: BND_W] = bnd_sel;
        reg_rdata[BLK_W-1:0]        = blk_size;
      end
      OFS_BCNT: reg_rdata[CNT_W-1:0] = blk_cnt;
      OFS_STAT: reg_rdata[1:0]       = {done_flag, irq_flag};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdma_agen_bnd.sv
module sdma_agen_bnd #(
  parameter int ADDR_W     = 32,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [BND_W-1:0]  bnd_sel,
  output logic              bnd_hit
);
  localparam int N_SEL = 1 << BND_W;
  logic [N_SEL-1:0] hit_vec;

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    assign hit_vec[g] = (next_addr[BASE_SHIFT+g-1:0] == '0);
  end

  assign bnd_hit = hit_vec[bnd_sel];
endmodule

// File: rtl/sdma_agen_seq.sv
module sdma_agen_seq #(
  parameter int ADDR_W     = 32,
  parameter int BLK_W      = 10,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              dma_en,
  input  logic              beat_valid,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [BLK_W-1:0]  blk_size,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic              bnd_hit,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              busy,
  output logic              beat_ready,
  output logic              set_irq,
  output logic              set_done
);
  localparam int BYTE_W = BLK_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic              busy_q, stall_q;
  logic [BYTE_W-1:0] byte_q, byte_nx;
  logic [CNT_W-1:0]  left_q;
  logic              beat_fire, blk_end, last_beat, start_ok;

  assign beat_ready = busy_q & ~stall_q;
  assign beat_fire  = beat_valid & beat_ready;
  assign next_addr  = addr_q + ADDR_W'(BEAT_BYTES);
  assign byte_nx    = byte_q + BYTE_W'(BEAT_BYTES);
  assign blk_end    = beat_fire & (byte_nx >= {1'b0, blk_size});
  assign last_beat  = blk_end & (left_q == CNT_W'(1));
  assign start_ok   = xfer_start & ~busy_q & (blk_cnt != '0);
  assign set_done   = last_beat;
  assign set_irq    = beat_fire & ~last_beat & dma_en & bnd_hit;
  assign cur_addr   = addr_q;
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      busy_q  <= 1'b0;
      stall_q <= 1'b0;
      byte_q  <= '0;
      left_q  <= '0;
    end else begin
      if (addr_we)        addr_q <= addr_wdata;
      else if (beat_fire) addr_q <= next_addr;

      if (start_ok)       busy_q <= 1'b1;
      else if (last_beat) busy_q <= 1'b0;

      if (start_ok)     stall_q <= 1'b0;
      else if (set_irq) stall_q <= 1'b1;
      else if (addr_we) stall_q <= 1'b0;

      if (start_ok || blk_end) byte_q <= '0;
      else if (beat_fire)      byte_q <= byte_nx;

      if (start_ok)     left_q <= blk_cnt;
      else if (blk_end) left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sdma_bndry_agen.sv
module sdma_bndry_agen
  import sdma_agen_pkg::*;
#(
  parameter int BLK_W      = 10,
  parameter int CNT_W      = 16,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xfer_start,
  input  logic        dma_en,
  input  logic        beat_valid,
  output logic        beat_ready,
  output logic [31:0] mem_addr,
  output logic        busy,
  output logic        dma_irq,
  output logic        xfer_done
);
  localparam int ADDR_W = 32;

  logic [BLK_W-1:0]  blk_size;
  logic [BND_W-1:0]  bnd_sel;
  logic [CNT_W-1:0]  blk_cnt;
  logic [ADDR_W-1:0] cur_addr, next_addr;
  logic              bnd_hit, set_irq, set_done, addr_we;

  assign addr_we  = reg_we & (reg_addr == OFS_ADDR);
  assign mem_addr = cur_addr;

  sdma_agen_regs #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W), .BND_W(BND_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wr_size(reg_wdata[BLK_W-1:0]), .wr_bnd(reg_wdata[BND_LSB +: BND_W]),
    .wr_cnt(reg_wdata[CNT_W-1:0]), .wr_clr(reg_wdata[1:0]),
    .busy(busy), .cur_addr(cur_addr), .set_irq(set_irq), .set_done(set_done),
    .blk_size(blk_size), .bnd_sel(bnd_sel), .blk_cnt(blk_cnt),
    .irq_flag(dma_irq), .done_flag(xfer_done), .reg_rdata(reg_rdata)
  );

  sdma_agen_bnd #(
    .ADDR_W(ADDR_W), .BND_W(BND_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_bnd (
    .next_addr(next_addr), .bnd_sel(bnd_sel), .bnd_hit(bnd_hit)
  );

  sdma_agen_seq #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .dma_en(dma_en),
    .beat_valid(beat_valid), .addr_we(addr_we), .addr_wdata(reg_wdata),
    .blk_size(blk_size), .blk_cnt(blk_cnt), .bnd_hit(bnd_hit),
    .cur_addr(cur_addr), .next_addr(next_addr), .busy(busy),
    .beat_ready(beat_ready), .set_irq(set_irq), .set_done(set_done)
  );
endmodule

// File: rtl/sdma_agen_chk.sv
module sdma_agen_chk
  import sdma_agen_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic        wdata0,
  input logic        dma_en,
  input logic        beat_valid,
  input logic        beat_ready,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        dma_irq,
  input logic        xfer_done,
  input logic [9:0]  bsr_size,
  input logic [2:0]  bsr_bnd
);
  logic addr_wr;
  assign addr_wr = reg_we && (reg_addr == OFS_ADDR);

  assert_irq_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_irq) |-> !beat_ready);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_ready && !addr_wr) |=> !beat_ready);

  assert_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && beat_valid && beat_ready) |=> (beat_ready || !busy));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !addr_wr) |=> (mem_addr == $past(mem_addr) + 32'd4));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> (!busy && !beat_ready));

  assert_bsr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == OFS_BSR) |=> ($stable(bsr_size) && $stable(bsr_bnd)));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq && !(reg_we && reg_addr == OFS_STAT && wdata0)) |=> dma_irq);
endmodule

bind sdma_bndry_agen sdma_agen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wdata0(reg_wdata[0]), .dma_en(dma_en), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .mem_addr(mem_addr), .busy(busy),
  .dma_irq(dma_irq), .xfer_done(xfer_done),
  .bsr_size(blk_size), .bsr_bnd(bnd_sel)
);

// File: tb/tb_sdma_bndry_agen.sv
module tb_sdma_bndry_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_start = 1'b0;
  logic        dma_en = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic [31:0] mem_addr;
  logic        busy, dma_irq, xfer_done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int vmode = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdma_bndry_agen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .dma_en(dma_en), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .mem_addr(mem_addr), .busy(busy), .dma_irq(dma_irq), .xfer_done(xfer_done)
  );

  // reference model state
  logic [31:0] m_addr, na;
  bit m_busy, m_stall, m_irq, m_done, fire, last, hit, was_busy;
  int m_bytes, m_left, m_bsz, m_bnd, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_busy = 0; m_stall = 0; m_irq = 0; m_done = 0;
      m_bytes = 0; m_left = 0; m_bsz = 0; m_bnd = 0; m_cnt = 0;
    end else begin
      was_busy = m_busy;
      fire = beat_valid && m_busy && !m_stall;
      last = 0; hit = 0;
      if (fire) begin
        na = m_addr + 32'd4;
        m_bytes += 4;
        if (m_bytes >= m_bsz) begin
          m_bytes = 0;
          m_left--;
          last = (m_left == 0);
        end
        hit = dma_en && !last && ((na % (32'd4096 << m_bnd)) == 0);
        m_addr = na;
      end
      if (reg_we && reg_addr == 8'h0C) begin
        if (reg_wdata[0]) m_irq = 0;
        if (reg_wdata[1]) m_done = 0;
      end
      if (hit) m_irq = 1;
      if (last) begin m_done = 1; m_busy = 0; end
      if (reg_we && reg_addr == 8'h00) begin
        m_addr = reg_wdata;
        m_stall = 0;
      end
      if (hit) m_stall = 1;
      if (xfer_start && !was_busy && m_cnt != 0) begin
        m_busy = 1; m_stall = 0; m_bytes = 0; m_left = m_cnt;
      end
      if (reg_we && !was_busy && reg_addr == 8'h04) begin
        m_bsz = int'(reg_wdata[9:0]);
        m_bnd = int'(reg_wdata[14:12]);
      end
      if (reg_we && !was_busy && reg_addr == 8'h08) m_cnt = int'(reg_wdata[15:0]);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      chk(mem_addr == m_addr, "R5 mem_addr", mem_addr, m_addr);
      chk(beat_ready == (m_busy && !m_stall), "R3 beat_ready", 32'(beat_ready), 32'(m_busy && !m_stall));
      chk(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
      chk(dma_irq == m_irq, "R2 dma_irq", 32'(dma_irq), 32'(m_irq));
      chk(xfer_done == m_done, "R6 xfer_done", 32'(xfer_done), 32'(m_done));
    end
    if (vmode == 0) beat_valid = 1'b1;
    else beat_valid = ($urandom_range(0, 2) != 0);
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic go();
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic wait_idle_or_irq();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy || dma_irq) break;
    end
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(mem_addr == 0 && !busy && !beat_ready && !dma_irq && !xfer_done, "R1 outputs", mem_addr, 0);
    rd(8'h00, 32'h0, "R1 addr reg");
    rd(8'h04, 32'h0, "R1 size reg");
    rd(8'h08, 32'h0, "R1 count reg");
    rd(8'h0C, 32'h0, "R1 status reg");

    // R10 start with zero count ignored
    go();
    repeat (2) @(negedge clk);
    chk(!busy, "R10 zero count start", 32'(busy), 0);

    // 4 KB boundary stall and resume
    dma_en = 1'b1; vmode = 0;
    wr(8'h00, 32'h0000_0FF0);
    wr(8'h04, 32'h0000_0010);
    wr(8'h08, 32'd3);
    rd(8'h04, 32'h0000_0010, "R7 size readback");
    go();
    wait_idle_or_irq();
    chk(dma_irq == 1'b1, "R2 irq at 4K", 32'(dma_irq), 1);
    chk(mem_addr == 32'h0000_1000, "R2 stall address", mem_addr, 32'h1000);
    repeat (4) @(negedge clk);
    chk(beat_ready == 1'b0, "R3 stays stalled", 32'(beat_ready), 0);
    go(); // R10 start while busy is ignored
    wr(8'h04, 32'h0000_7020); // R7 ignored while busy
    wr(8'h08, 32'd9);
    wr(8'h0C, 32'h1);
    chk(dma_irq == 1'b0, "R8 W1C clears irq", 32'(dma_irq), 0);
    wr(8'h00, 32'h0000_1000);
    wait_idle_or_irq();
    chk(xfer_done == 1'b1 && !busy, "R6 done after three blocks", 32'(xfer_done), 1);
    rd(8'h00, 32'h0000_1020, "R5 final address");
    rd(8'h04, 32'h0000_0010, "R7 write while busy ignored");
    rd(8'h08, 32'd3, "R7 count write while busy ignored");
    rd(8'h0C, 32'h2, "R8 done flag sticky");
    wr(8'h0C, 32'h2);

    // R9 last beat lands on boundary
    wr(8'h00, 32'h0000_1FE0);
    wr(8'h04, 32'h0000_0020);
    wr(8'h08, 32'd1);
    go();
    wait_idle_or_irq();
    #4;
    chk(xfer_done && !dma_irq, "R9 completion not stall", {30'b0, dma_irq, xfer_done}, 32'h1);
    chk(mem_addr == 32'h0000_2000, "R9 final address", mem_addr, 32'h2000);
    wr(8'h0C, 32'h3);

    // R4 DMA disabled: cross boundary freely, gappy stream
    dma_en = 1'b0; vmode = 1;
    wr(8'h00, 32'h0000_3FF0);
    go();
    wait_idle_or_irq();
    #4;
    chk(!dma_irq && xfer_done, "R4 no stall when disabled", 32'(dma_irq), 0);
    chk(mem_addr == 32'h0000_4010, "R4 final address", mem_addr, 32'h4010);
    wr(8'h0C, 32'h3);

    // R2 32 KB setting: 4 KB multiple passes, 32 KB multiple stalls
    dma_en = 1'b1; vmode = 0;
    wr(8'h00, 32'h0000_6FF8);
    wr(8'h04, 32'h0000_3008);
    wr(8'h08, 32'd4);
    rd(8'h04, 32'h0000_3008, "R7 field positions");
    go();
    wait_idle_or_irq();
    #4;
    chk(!dma_irq && xfer_done, "R2 no stall at 4K with 32K field", 32'(dma_irq), 0);
    wr(8'h0C, 32'h3);
    wr(8'h00, 32'h0000_7FF0);
    go();
    wait_idle_or_irq();
    chk(dma_irq && mem_addr == 32'h0000_8000, "R2 stall at 32K", mem_addr, 32'h8000);

    // R8 clear and set in the same cycle: set wins
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h0000_FFF8);
    wr(8'h0C, 32'h1);
    #1;
    chk(dma_irq == 1'b1, "R8 set wins over clear", 32'(dma_irq), 1);
    chk(mem_addr == 32'h0001_0000 && !beat_ready, "R3 stall at 64K multiple", mem_addr, 32'h10000);
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h0001_0000);
    wait_idle_or_irq();
    #4;
    chk(xfer_done && !busy, "R6 done after resume", 32'(xfer_done), 1);
    rd(8'h00, 32'h0001_0008, "R5 address after resume");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule